// File: doc/BRIEF.md
# DMA Interrupt Status and Control Register

This block is the 32-bit interrupt status and control register that sits beside a set of DMA channels. Each channel reports two kinds of events by a single-cycle pulse: the normal end of a transfer and an aborted transfer caused by a bus error. The register collects these events into per-channel flags and reduces them, together with a global error bit, into one level-high interrupt line.

Software programs the per-channel enables, a master enable and six general-purpose control bits by a full-word write. It acknowledges interrupts by writing ones to the flag bits it wants to clear. The summary bit at the top of the word is not stored. It is recomputed every cycle from the stored bits, and the interrupt output always equals it.

Completion and bus errors are treated differently. A completion raises a flag only when software asked for it. A bus error raises the global error bit and the channel's flag whatever the enables hold, so a failed transfer can never go unnoticed.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset every bit of `rd_data` is 0 and `irq_o` is 0.
- R2: A write loads bits 5:0, bit 15 (global bus-error bit), bits 16+c (enable of channel c) and bit 23 (master enable) from `wr_data`; bits 14:6 and enable or flag bits of channels that do not exist always read 0.
- R3: Bit 31 is read-only: writing a 1 to it has no effect on any bit.
- R4: Flag bits 24+c are write-one-to-clear: a written 1 clears the flag, a written 0 leaves it, and a write can never set a flag.
- R5: A pulse on `done_i[c]` sets flag 24+c on the next clock only if channel c's enable and the master enable both already hold 1 before that clock; a write in the same cycle does not change the gating.
- R6: A pulse on `bus_err_i[c]` sets bit 15 and flag 24+c on the next clock, whatever the enables hold.
- R7: Bit 31 reads 1 exactly when bit 15 is 1, or bit 23 is 1 and at least one flag in 30:24 is 1; `irq_o` equals bit 31 at all times.
- R8: When an event sets a flag or bit 15 in the same cycle that a write clears it, the bit ends up set.
- R9: Flags and bit 15 hold their value in cycles with no write and no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write data |
| done_i | input | NUM_CH | Per-channel transfer-complete pulses |
| bus_err_i | input | NUM_CH | Per-channel bus-error pulses |
| rd_data | output | 32 | Current register value |
| irq_o | output | 1 | Interrupt request, level high |

## Verification
The bench builds the register twice. The default seven-channel build carries the vector table and the directed tests, so every enable and flag position, including channel 6 at the top of each field, is driven by events and writes. A second build with three channels reaches the padding case: all-ones writes and events must leave the unused enable and flag positions reading zero. It also shows that the gating and the error path still line up with the fixed bit positions.

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] bus_err_i,
  output logic [31:0]       rd_data,
  output logic              irq_o
);
  localparam int CTRL_W  = 6;
  localparam int ERR_BIT = 15;
  localparam int EN_LO   = 16;
  localparam int MEN_BIT = 23;
  localparam int FLG_LO  = 24;
  localparam int TOP_BIT = 31;

  logic [CTRL_W-1:0] ctrl_q;
  logic              err_q;
  logic [NUM_CH-1:0] en_q;
  logic              men_q;
  logic [NUM_CH-1:0] flg_q;

  logic [NUM_CH-1:0] clr_mask;
  logic [NUM_CH-1:0] set_mask;
  logic              summary;
  logic              unused_wr;

  assign unused_wr = ^wr_data;

  assign clr_mask = wr_en ? wr_data[FLG_LO +: NUM_CH] : '0;
  assign set_mask = bus_err_i | (done_i & en_q & {NUM_CH{men_q}});
  assign summary  = err_q | (men_q & (|flg_q));
  assign irq_o    = summary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      err_q  <= 1'b0;
      en_q   <= '0;
      men_q  <= 1'b0;
      flg_q  <= '0;
    end else begin
      if (wr_en) begin
        ctrl_q <= wr_data[CTRL_W-1:0];
        en_q   <= wr_data[EN_LO +: NUM_CH];
        men_q  <= wr_data[MEN_BIT];
      end
      err_q <= (wr_en ? wr_data[ERR_BIT] : err_q) | (|bus_err_i);
      flg_q <= (flg_q & ~clr_mask) | set_mask;
    end
  end

  always_comb begin
    rd_data                   = '0;
    rd_data[CTRL_W-1:0]       = ctrl_q;
    rd_data[ERR_BIT]          = err_q;
    rd_data[EN_LO +: NUM_CH]  = en_q;
    rd_data[MEN_BIT]          = men_q;
    rd_data[FLG_LO +: NUM_CH] = flg_q;
    rd_data[TOP_BIT]          = summary;
  end

  assert_irq_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (rd_data[ERR_BIT] | (rd_data[MEN_BIT] & (|rd_data[30:24]))));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_err_i) |=> rd_data[ERR_BIT]);

  assert_top_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[TOP_BIT] && !(|bus_err_i) && !wr_data[ERR_BIT] && !wr_data[MEN_BIT])
      |=> !rd_data[TOP_BIT]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_err_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err_i[c] |=> rd_data[FLG_LO + c]);

    assert_done_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i[c] && rd_data[EN_LO + c] && rd_data[MEN_BIT]) |=> rd_data[FLG_LO + c]);

    assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_data[FLG_LO + c] && !bus_err_i[c] &&
       !(done_i[c] && rd_data[EN_LO + c] && rd_data[MEN_BIT])) |=> !rd_data[FLG_LO + c]);

    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[FLG_LO + c] && !done_i[c] && !bus_err_i[c]) |=> !rd_data[FLG_LO + c]);

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && rd_data[FLG_LO + c]) |=> rd_data[FLG_LO + c]);
  end
endmodule

// File: tb/dma_irq_ctrl_tb.sv
module dma_irq_ctrl_tb;
  localparam int N  = 7;
  localparam int NN = 3;
  localparam int NV = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [N-1:0]  done_i = '0;
  logic [N-1:0]  bus_err_i = '0;
  logic [31:0]   rd_data;
  logic          irq_o;

  logic          n_wr_en = 1'b0;
  logic [31:0]   n_wr_data = '0;
  logic [NN-1:0] n_done = '0;
  logic [NN-1:0] n_berr = '0;
  logic [31:0]   n_rd;
  logic          n_irq;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #4 clk = ~clk;

  dma_irq_ctrl #(.NUM_CH(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .done_i(done_i), .bus_err_i(bus_err_i), .rd_data(rd_data), .irq_o(irq_o));

  dma_irq_ctrl #(.NUM_CH(NN)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n), .wr_en(n_wr_en), .wr_data(n_wr_data),
    .done_i(n_done), .bus_err_i(n_berr), .rd_data(n_rd), .irq_o(n_irq));

  // {wr_en, wr_data, done, bus_err, expected rd_data}
  localparam logic [78:0] VEC [NV] = '{
    {1'b1, 32'h007F_C03F, 7'h00, 7'h00, 32'h807F_803F}, // R2 R7 bit14 dropped, err via write
    {1'b1, 32'h0000_0000, 7'h00, 7'h00, 32'h0000_0000}, // R2
    {1'b1, 32'h0085_0000, 7'h00, 7'h00, 32'h0085_0000}, // R2
    {1'b0, 32'h0000_0000, 7'h01, 7'h00, 32'h8185_0000}, // R5 enabled completion
    {1'b0, 32'h0000_0000, 7'h02, 7'h00, 32'h8185_0000}, // R5 channel disabled
    {1'b1, 32'h0185_0000, 7'h00, 7'h00, 32'h0085_0000}, // R4
    {1'b1, 32'h0005_0000, 7'h00, 7'h00, 32'h0005_0000}, // R2
    {1'b0, 32'h0000_0000, 7'h04, 7'h00, 32'h0005_0000}, // R5 master off
    {1'b0, 32'h0000_0000, 7'h00, 7'h40, 32'hC005_8000}, // R6 ungated error
    {1'b1, 32'h4005_0000, 7'h00, 7'h00, 32'h0005_0000}, // R4
    {1'b1, 32'h0085_0000, 7'h04, 7'h00, 32'h0085_0000}, // R5 gating uses pre-write enables
    {1'b0, 32'h0000_0000, 7'h05, 7'h00, 32'h8585_0000}, // R5
    {1'b1, 32'h8085_0000, 7'h00, 7'h00, 32'h8585_0000}, // R3
    {1'b1, 32'h0585_0000, 7'h04, 7'h00, 32'h8485_0000}, // R8 done beats clear
    {1'b1, 32'h0285_0000, 7'h00, 7'h02, 32'h8685_8000}, // R8 error beats clear
    {1'b1, 32'h0605_0000, 7'h00, 7'h00, 32'h0005_0000}, // R4
    {1'b1, 32'h7F00_0000, 7'h00, 7'h00, 32'h0000_0000}, // R4 write cannot set
    {1'b0, 32'h0000_0000, 7'h00, 7'h01, 32'h8100_8000}, // R6 R7
    {1'b1, 32'h0000_0000, 7'h00, 7'h00, 32'h0100_0000}, // R7 master off hides flag
    {1'b1, 32'h0080_0000, 7'h00, 7'h00, 32'h8180_0000}  // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  initial begin
    #3000000;
    if (!done_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd", rd_data, 32'h0);
    check("R1 irq", {31'd0, irq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr_en     = VEC[i][78];
      wr_data   = VEC[i][77:46];
      done_i    = VEC[i][45:39];
      bus_err_i = VEC[i][38:32];
      @(posedge clk);
      #1;
      check($sformatf("vector %0d rd", i), rd_data, VEC[i][31:0]);
      check($sformatf("R7 vector %0d irq", i), {31'd0, irq_o}, {31'd0, VEC[i][31]});
      @(negedge clk);
    end
    wr_en = 1'b0; done_i = '0; bus_err_i = '0;

    repeat (4) @(negedge clk);
    check("R9 hold", rd_data, 32'h8180_0000);

    @(negedge clk); bus_err_i = 7'h7F;
    @(negedge clk); bus_err_i = '0;
    check("R6 all channels", rd_data, 32'hFF80_8000);

    rst_n = 1'b0;
    #1;
    check("R1 async reset", rd_data, 32'h0);
    check("R1 irq after reset", {31'd0, irq_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    n_wr_en = 1'b1; n_wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    n_wr_en = 1'b0;
    check("R2 narrow padding", n_rd, 32'h8087_803F);
    n_berr = 3'b100; n_done = 3'b011;
    @(negedge clk);
    n_berr = '0; n_done = '0;
    check("R6 narrow flags", n_rd, 32'h8787_803F);
    n_wr_en = 1'b1; n_wr_data = 32'hFF00_0000;
    @(negedge clk);
    n_wr_en = 1'b0;
    check("R4 narrow clear", n_rd, 32'h0000_0000);

    done_run = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule